// File: doc/BRIEF.md
# Multi-Stream SDI Receive Line-Number and CRC Checker

This block sits behind the deserializer of a 6G-class serial video receiver. That deserializer delivers either four or eight interleaved 10-bit data streams in parallel. The block produces the word-rate enable for the chosen stream count. It samples every active stream on enabled cycles only.

For each active stream the block finds timing reference sequences and picks out the line number carried after every end-of-active-video marker. It also runs a line CRC and compares the result with the check words the stream carries. Each stream has its own line-number output and its own error flag. Two shared flags report a timing reference sequence and an end-of-active-video marker in the most recently sampled words.

A single mode input selects four-stream or eight-stream operation. Serial descrambling, word alignment and standard detection are handled upstream.

Top module: `sdi_multi_rx_chk`

## Requirements
- R1: With `mode8` low, `ce_out` is high on every cycle once reset has been released.
- R2: With `mode8` high, `ce_out` alternates between high and low on successive cycles, giving a 50% duty cycle.
- R3: Words on `ds_in` are sampled only on cycles where `ce_out` is high. Values present while `ce_out` is low have no effect on any output.
- R4: A timing reference is the word run 3FFh, 000h, 000h on a stream followed by a fourth word, called the marker. `trs_flag` is 1 after a sampled marker and 0 after any other sampled word. `eav_flag` is 1 when that marker has bit 6 set (end of active video, e.g. 274h) and 0 otherwise (start of active video, e.g. 200h). Both flags hold their value while `ce_out` is low.
- R5: After an end-of-active-video marker, the next two words of a stream are the line words. Line bits [6:0] are taken from bits [8:2] of the first line word, and line bits [10:7] from bits [5:2] of the second. That stream's `line_num` entry changes only once the second line word has been sampled.
- R6: The CRC of each stream starts from zero after a start-of-active-video marker. It covers every word after that marker up to and including the second line word, each word fed LSB first through x^18+x^5+x^4+1. The two words after the second line word carry CRC bits [8:0] and [17:9] in their bits [8:0]. The stream's `crc_err` bit becomes 1 if either part differs, and 0 if both match.
- R7: A stream's `crc_err` bit changes only when its second check word is sampled, and holds between checks. That check is skipped, and the bit kept, when no start-of-active-video marker arrived on that stream since the previous check.
- R8: With `mode8` low, streams 5 to 8 are ignored: their `line_num` and `crc_err` entries keep their value.
- R9: After reset, all `line_num` entries, all `crc_err` bits, `trs_flag` and `eav_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode8 | input | 1 | 1 selects eight streams, 0 selects four streams |
| ds_in | input | 8x10 | Interleaved stream words, entry 0 is stream 1 |
| ce_out | output | 1 | Word enable for the selected stream count |
| trs_flag | output | 1 | Timing reference marker seen on the last sampled word |
| eav_flag | output | 1 | That marker was end of active video |
| line_num | output | 8x11 | Captured line number per stream |
| crc_err | output | 8 | Per-stream line CRC mismatch flag |

## Verification
The assertions assume that `mode8` changes only while reset is asserted, so the enable cadence never has to restart mid-run. They also assume the line and check words on every active stream are aligned, so the shared flags and per-stream strobes line up. The stimulus changes mode only through a reset sequence and feeds all streams in lockstep. Active payload words are kept between 040h and 3BFh, so no false timing reference can appear. On disabled cycles the stimulus deliberately drives 3FFh, which stays harmless only if sampling honours the enable.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;

  localparam int WORD_W = 10;
  localparam int LN_W   = 11;
  localparam int CRC_W  = 18;
  localparam int LNLO_W = 7;

  // x^18 + x^5 + x^4 + 1, bit-reversed for an LSB-first right-shift register
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 18'h23000;

  typedef enum logic [2:0] {
    POS_IDLE = 3'd0,
    POS_LN0  = 3'd1,
    POS_LN1  = 3'd2,
    POS_CK0  = 3'd3,
    POS_CK1  = 3'd4
  } word_pos_e;

  function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[0] ^ w[i];
      r  = {1'b0, r[CRC_W-1:1]};
      if (fb) r = r ^ CRC_POLY_REV;
    end
    return r;
  endfunction

endpackage

// File: rtl/sdi_rx_cadence.sv
module sdi_rx_cadence (
  input  logic clk,
  input  logic rst_n,
  input  logic mode8,
  output logic ce
);

  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign ce = mode8 ? phase_q : 1'b1;

endmodule

// File: rtl/sdi_rx_trs.sv
module sdi_rx_trs #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic         trs_hit,
  output logic         eav_hit,
  output logic         sav_hit
);

  localparam logic [W-1:0] ONES  = '1;
  localparam logic [W-1:0] ZEROS = '0;
  localparam int HBIT = 6;

  logic [W-1:0] h1_q, h2_q, h3_q;
  logic [W-1:0] h1_d, h2_d, h3_d;

  always_comb begin
    h1_d = h1_q;
    h2_d = h2_q;
    h3_d = h3_q;
    if (en) begin
      h1_d = din;
      h2_d = h1_q;
      h3_d = h2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_q <= '0;
      h2_q <= '0;
      h3_q <= '0;
    end else begin
      h1_q <= h1_d;
      h2_q <= h2_d;
      h3_q <= h3_d;
    end
  end

  assign trs_hit = en && (h3_q == ONES) && (h2_q == ZEROS) && (h1_q == ZEROS);
  assign eav_hit = trs_hit &&  din[HBIT];
  assign sav_hit = trs_hit && !din[HBIT];

endmodule

// File: rtl/sdi_rx_lane.sv
module sdi_rx_lane
  import sdi_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic              trs_hit,
  output logic              eav_hit,
  output logic [LN_W-1:0]   ln_q,
  output logic              err_q,
  output logic              ln_stb,
  output logic              chk_stb
);

  logic sav_hit;

  sdi_rx_trs #(.W(WORD_W)) trs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .din     (din),
    .trs_hit (trs_hit),
    .eav_hit (eav_hit),
    .sav_hit (sav_hit)
  );

  word_pos_e          pos_q, pos_d;
  logic               run_q, run_d;
  logic               armed_q, armed_d;
  logic [CRC_W-1:0]   crc_q, crc_d;
  logic [LNLO_W-1:0]  lnlo_q, lnlo_d;
  logic               lobad_q, lobad_d;
  logic [LN_W-1:0]    ln_d;
  logic               err_d;
  logic               body;

  assign body    = en && !trs_hit;
  assign ln_stb  = body && (pos_q == POS_LN1);
  assign chk_stb = body && (pos_q == POS_CK1) && armed_q;

  always_comb begin
    pos_d   = pos_q;
    run_d   = run_q;
    armed_d = armed_q;
    crc_d   = crc_q;
    lnlo_d  = lnlo_q;
    lobad_d = lobad_q;
    ln_d    = ln_q;
    err_d   = err_q;
    if (en) begin
      if (run_q) crc_d = crc_word(crc_q, din);
      if (sav_hit) begin
        crc_d   = '0;
        run_d   = 1'b1;
        armed_d = 1'b1;
        pos_d   = POS_IDLE;
      end else if (eav_hit) begin
        pos_d = POS_LN0;
      end else begin
        unique case (pos_q)
          POS_LN0: begin
            lnlo_d = din[8:2];
            pos_d  = POS_LN1;
          end
          POS_LN1: begin
            ln_d  = {din[5:2], lnlo_q};
            run_d = 1'b0;
            pos_d = POS_CK0;
          end
          POS_CK0: begin
            lobad_d = (din[8:0] != crc_q[8:0]);
            pos_d   = POS_CK1;
          end
          POS_CK1: begin
            if (armed_q) err_d = lobad_q || (din[8:0] != crc_q[17:9]);
            armed_d = 1'b0;
            pos_d   = POS_IDLE;
          end
          default: pos_d = POS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= POS_IDLE;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      crc_q   <= '0;
      lnlo_q  <= '0;
      lobad_q <= 1'b0;
      ln_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      run_q   <= run_d;
      armed_q <= armed_d;
      crc_q   <= crc_d;
      lnlo_q  <= lnlo_d;
      lobad_q <= lobad_d;
      ln_q    <= ln_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/sdi_multi_rx_chk.sv
module sdi_multi_rx_chk
  import sdi_rx_pkg::*;
#(
  parameter int NUM_STREAMS = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   mode8,
  input  logic [NUM_STREAMS-1:0][WORD_W-1:0]     ds_in,
  output logic                                   ce_out,
  output logic                                   trs_flag,
  output logic                                   eav_flag,
  output logic [NUM_STREAMS-1:0][LN_W-1:0]       line_num,
  output logic [NUM_STREAMS-1:0]                 crc_err
);

  localparam int BASE_STREAMS = NUM_STREAMS / 2;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  sdi_rx_cadence cad_i (
    .clk   (clk),
    .rst_n (rst_q),
    .mode8 (mode8),
    .ce    (ce_out)
  );

  logic [NUM_STREAMS-1:0] trs_vec, eav_vec, ln_stb, chk_stb;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane
    logic lane_en;
    if (i < BASE_STREAMS) begin : g_base
      assign lane_en = ce_out;
    end else begin : g_ext
      assign lane_en = ce_out && mode8;
    end

    sdi_rx_lane lane_i (
      .clk     (clk),
      .rst_n   (rst_q),
      .en      (lane_en),
      .din     (ds_in[i]),
      .trs_hit (trs_vec[i]),
      .eav_hit (eav_vec[i]),
      .ln_q    (line_num[i]),
      .err_q   (crc_err[i]),
      .ln_stb  (ln_stb[i]),
      .chk_stb (chk_stb[i])
    );
  end

  logic trs_d, eav_d;

  always_comb begin
    trs_d = trs_flag;
    eav_d = eav_flag;
    if (ce_out) begin
      trs_d = |trs_vec;
      eav_d = |eav_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      trs_flag <= 1'b0;
      eav_flag <= 1'b0;
    end else begin
      trs_flag <= trs_d;
      eav_flag <= eav_d;
    end
  end

endmodule

// File: rtl/sdi_multi_rx_chk_sva.sv
module sdi_multi_rx_chk_sva
  import sdi_rx_pkg::*;
#(
  parameter int NUM_STREAMS = 8
) (
  input logic                              clk,
  input logic                              rst_q,
  input logic                              mode8,
  input logic                              ce_out,
  input logic                              trs_flag,
  input logic                              eav_flag,
  input logic [NUM_STREAMS-1:0][LN_W-1:0]  line_num,
  input logic [NUM_STREAMS-1:0]            crc_err,
  input logic [NUM_STREAMS-1:0]            ln_stb,
  input logic [NUM_STREAMS-1:0]            chk_stb
);

  localparam int HALF = NUM_STREAMS / 2;

  // R1
  ce_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !mode8 |-> ce_out);

  // R2
  ce_alternate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mode8 && $past(mode8) && $past(rst_q)) |-> (ce_out != $past(ce_out)));

  // R4
  eav_needs_trs_chk: assert property (@(posedge clk) disable iff (!rst_q)
    eav_flag |-> trs_flag);

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(ce_out) |-> ($stable(trs_flag) && $stable(eav_flag)));

  // R8
  idle_lanes_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!mode8 && !$past(mode8)) |->
      ($stable(line_num[NUM_STREAMS-1:HALF]) && $stable(crc_err[NUM_STREAMS-1:HALF])));

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane_chk
    // R5
    ln_only_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_q)
      !$stable(line_num[i]) |-> $past(ln_stb[i]));
    // R7
    err_only_on_check_chk: assert property (@(posedge clk) disable iff (!rst_q)
      !$stable(crc_err[i]) |-> $past(chk_stb[i]));
  end

endmodule

bind sdi_multi_rx_chk sdi_multi_rx_chk_sva #(.NUM_STREAMS(NUM_STREAMS)) sva_i (
  .clk      (clk),
  .rst_q    (rst_q),
  .mode8    (mode8),
  .ce_out   (ce_out),
  .trs_flag (trs_flag),
  .eav_flag (eav_flag),
  .line_num (line_num),
  .crc_err  (crc_err),
  .ln_stb   (ln_stb),
  .chk_stb  (chk_stb)
);

// File: tb/sdi_multi_rx_chk_tb_top.sv
module sdi_multi_rx_chk_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                  rst_n;
  logic                  mode8;
  logic [NS-1:0][9:0]    ds_in;
  logic                  ce_out, trs_flag, eav_flag;
  logic [NS-1:0][10:0]   line_num;
  logic [NS-1:0]         crc_err;

  sdi_multi_rx_chk #(.NUM_STREAMS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode8(mode8), .ds_in(ds_in),
    .ce_out(ce_out), .trs_flag(trs_flag), .eav_flag(eav_flag),
    .line_num(line_num), .crc_err(crc_err)
  );

  int checks = 0;
  int errors = 0;

  logic [9:0]  wv [NS];
  logic [17:0] crc_m [NS];
  logic [10:0] exp_ln [NS];
  logic [NS-1:0] exp_err;
  bit acc;

  // {mode8, line, seed, corrupt mask}
  localparam logic [27:0] VEC [6] = '{
    {1'b0, 11'd21,   8'd3,   8'h00},
    {1'b0, 11'd22,   8'd9,   8'h05},
    {1'b0, 11'd23,   8'd17,  8'hF0},
    {1'b1, 11'd1124, 8'd40,  8'h81},
    {1'b1, 11'd2044, 8'd77,  8'h00},
    {1'b1, 11'd5,    8'd200, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] crc_upd(input logic [17:0] c, input logic [9:0] w);
    logic [17:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 10; b++) begin
      fb = r[0] ^ w[b];
      r = {fb, r[17:1]};
      r[13] = r[13] ^ fb;
      r[12] = r[12] ^ fb;
    end
    return r;
  endfunction

  // one word per stream on an enabled cycle; 3FFh driven while disabled (R3)
  task automatic step();
    while (!ce_out) @(negedge clk);
    for (int l = 0; l < NS; l++) ds_in[l] = wv[l];
    @(negedge clk);
    for (int l = 0; l < NS; l++) ds_in[l] = 10'h3FF;
  endtask

  task automatic put();
    if (acc) for (int l = 0; l < NS; l++) crc_m[l] = crc_upd(crc_m[l], wv[l]);
    step();
  endtask

  task automatic put_all(input logic [9:0] w);
    for (int l = 0; l < NS; l++) wv[l] = w;
    put();
  endtask

  task automatic do_reset(input bit m);
    rst_n = 1'b0;
    mode8 = m;
    for (int l = 0; l < NS; l++) begin
      ds_in[l] = '0;
      exp_ln[l] = '0;
      crc_m[l] = '0;
    end
    exp_err = '0;
    acc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9
    chk(trs_flag == 1'b0 && eav_flag == 1'b0, "R9", "flags after reset", {trs_flag, eav_flag}, 0);
    chk(crc_err == '0, "R9", "crc_err after reset", crc_err, 0);
    chk(line_num == '0, "R9", "line_num after reset", line_num[0], 0);
    if (m) begin
      logic prev;
      prev = ce_out;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(ce_out != prev, "R2", "ce alternation", ce_out, !prev);
        prev = ce_out;
      end
    end else begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(ce_out == 1'b1, "R1", "ce full rate", ce_out, 1);
      end
    end
  endtask

  task automatic send_line(input logic [10:0] ln, input logic [7:0] seed,
                           input logic [NS-1:0] bad, input bit with_sav);
    logic [10:0] lv;
    bit active;
    if (with_sav) begin
      acc = 1'b0;
      put_all(10'h3FF); put_all(10'h000); put_all(10'h000); put_all(10'h200);
      chk(trs_flag == 1'b1, "R4", "trs on start marker", trs_flag, 1);
      chk(eav_flag == 1'b0, "R4", "eav on start marker", eav_flag, 0);
      for (int l = 0; l < NS; l++) crc_m[l] = '0;
      acc = 1'b1;
    end
    for (int k = 0; k < 6; k++) begin
      for (int l = 0; l < NS; l++)
        wv[l] = 10'h040 + 10'((int'(seed) * 37 + l * 11 + k * 53) % 896);
      put();
      if (k == 0) chk(trs_flag == 1'b0, "R4", "trs on payload", trs_flag, 0);
    end
    // R7: flags hold until this line's check
    chk(crc_err == exp_err, "R7", "crc_err held mid-line", crc_err, exp_err);
    put_all(10'h3FF); put_all(10'h000); put_all(10'h000); put_all(10'h274);
    chk(trs_flag == 1'b1 && eav_flag == 1'b1, "R4", "flags on end marker", {trs_flag, eav_flag}, 3);
    for (int l = 0; l < NS; l++) begin
      lv = ln + 11'(l);
      wv[l] = {~lv[6], lv[6:0], 2'b00};
    end
    put();
    for (int l = 0; l < NS; l++) begin
      lv = ln + 11'(l);
      wv[l] = {1'b1, 3'b000, lv[10:7], 2'b00};
    end
    put();
    acc = 1'b0;
    for (int l = 0; l < NS; l++) wv[l] = {~crc_m[l][8], crc_m[l][8:0]} ^ {9'd0, bad[l]};
    put();
    for (int l = 0; l < NS; l++) wv[l] = {~crc_m[l][17], crc_m[l][17:9]};
    put();
    for (int l = 0; l < NS; l++) begin
      active = (l < NS/2) || mode8;
      if (active) begin
        exp_ln[l] = ln + 11'(l);
        if (with_sav) exp_err[l] = bad[l];
      end
      chk(line_num[l] == exp_ln[l], active ? "R5" : "R8", "line_num", line_num[l], exp_ln[l]);
      chk(crc_err[l] == exp_err[l], active ? (with_sav ? "R6" : "R7") : "R8", "crc_err",
          crc_err[l], exp_err[l]);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d cycles", WATCHDOG, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit cur_mode;
    rst_n = 1'b0;
    mode8 = 1'b0;
    ds_in = '0;
    do_reset(1'b0);
    cur_mode = 1'b0;
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][27] != cur_mode) begin
        cur_mode = VEC[v][27];
        do_reset(cur_mode);
      end
      send_line(VEC[v][26:16], VEC[v][15:8], VEC[v][7:0], 1'b1);
    end
    // R6: a clean line clears every flag
    send_line(11'd300, 8'd11, 8'h00, 1'b1);
    // R7: corrupt check words with no start marker since the last check
    send_line(11'd301, 8'd12, 8'hFF, 1'b0);
    // R3 and R8 in four-stream mode after eight-stream traffic
    do_reset(1'b0);
    send_line(11'd1500, 8'd99, 8'hFA, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule